// File: doc/BRIEF.md
# Master-to-Word Clock Ratio Sensor with Bit-Clock Divider

This block runs on the master clock and watches a word clock that is synchronous to it. After reset it waits for a rising word-clock edge. It then counts master-clock cycles until the next rising edge and compares the count with the three supported ratios: 256, 384 and 512. A match raises the lock flag and latches a ratio code. Any other count leaves the flag low, and the block measures the following period instead. Once set, the lock and the code hold until reset.

When locked in internal mode, the block produces a one-cycle enable for the serial bit clock. The divider is 8 at ratio 256, 8 at ratio 384 and 16 at ratio 512. This gives 32 enables per word period at ratio 256 or 512 and 48 at ratio 384. The divider restarts on every word-clock transition, so each half of the word period starts on a clean bit boundary. The block also reports the longest sample word allowed in the current mode. External bit-clock mode allows 24 bits. Internal mode allows 24 bits at ratio 384 and 16 bits at ratio 256 or 512.

Top module: `clkratio_sense`

## Requirements
- R1: While reset is held and on the first cycle after it, `locked` is 0, `ratio_code` is 0 and `bclk_en` is 0.
- R2: The period is the number of master-clock cycles between two successive rising word-clock edges. The first rising edge after reset only arms the measurement. At the second rising edge, a period of 256, 384 or 512 sets `locked` and sets `ratio_code` to 1, 2 or 3 respectively.
- R3: A period that matches none of the three ratios keeps `locked` at 0 and `ratio_code` at 0. Measurement repeats on each following period, and a later valid period still locks.
- R4: Once `locked` is 1, it and `ratio_code` stay unchanged until reset, even if the word-clock period changes.
- R5: In internal mode with `locked` high, `bclk_en` is high once every 8 cycles for codes 1 and 2 and once every 16 cycles for code 3. This gives 32, 48 and 32 enables per 256, 384 and 512 cycle word period.
- R6: Any word-clock transition restarts the divider, so `bclk_en` is low in the cycle after a transition. The first enable comes one full divide length after that transition.
- R7: `bclk_en` is 0 whenever `ext_sclk_mode` is 1 or `locked` is 0.
- R8: `max_bits` is 24 when `ext_sclk_mode` is 1. In internal mode it is 24 for code 2, 16 for codes 1 and 3, and 0 while unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lrck | input | 1 | Word clock, synchronous to mclk |
| ext_sclk_mode | input | 1 | 1 selects external bit-clock mode |
| ratio_code | output | 2 | 0 none, 1 = 256, 2 = 384, 3 = 512 |
| locked | output | 1 | A supported ratio has been detected |
| bclk_en | output | 1 | One-cycle internal bit-clock enable |
| max_bits | output | 5 | Longest accepted sample word in bits |

## Verification
Two things can land on the same master-clock cycle: the divider reaching its terminal count and a word-clock transition restarting it. The same is true of the locking rising edge and a divider restart. With word halves that are exact multiples of the divide length, every transition coincides with a terminal count. The bench then requires exactly 32 or 48 enables per period, with no extra or lost pulse. Uneven halves of 195 and 189 cycles at ratio 384 must yield 24 + 23 enables rather than the 48 a free-running divider would give.

// File: rtl/clkratio_sense.sv
module clkratio_sense #(
  parameter int RATIO_LO    = 256,
  parameter int RATIO_MID   = 384,
  parameter int RATIO_HI    = 512,
  parameter int DIV_LO      = 8,
  parameter int DIV_MID     = 8,
  parameter int DIV_HI      = 16,
  parameter int BITS_WIDE   = 24,
  parameter int BITS_NARROW = 16
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       lrck,
  input  logic       ext_sclk_mode,
  output logic [1:0] ratio_code,
  output logic       locked,
  output logic       bclk_en,
  output logic [$clog2(BITS_WIDE+1)-1:0] max_bits
);

  localparam int CW   = $clog2(RATIO_HI + 1);
  localparam int DMAX = (DIV_HI > DIV_MID) ? ((DIV_HI > DIV_LO) ? DIV_HI : DIV_LO)
                                           : ((DIV_MID > DIV_LO) ? DIV_MID : DIV_LO);
  localparam int DW   = (DMAX > 1) ? $clog2(DMAX) : 1;
  localparam int MBW  = $clog2(BITS_WIDE + 1);

  logic          lrck_q;
  logic          armed;
  logic [CW-1:0] cnt;
  logic [DW-1:0] div;
  logic [DW-1:0] div_last;
  logic [1:0]    hit;

  wire rise     = lrck & ~lrck_q;
  wire edge_any = lrck ^ lrck_q;

  always_comb begin
    hit = 2'd0;
    if (cnt == CW'(RATIO_LO - 1))  hit = 2'd1;
    if (cnt == CW'(RATIO_MID - 1)) hit = 2'd2;
    if (cnt == CW'(RATIO_HI - 1))  hit = 2'd3;
  end

  always_comb begin
    case (ratio_code)
      2'd3:    div_last = DW'(DIV_HI - 1);
      2'd2:    div_last = DW'(DIV_MID - 1);
      default: div_last = DW'(DIV_LO - 1);
    endcase
  end

  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      lrck_q     <= 1'b0;
      armed      <= 1'b0;
      cnt        <= '0;
      div        <= '0;
      locked     <= 1'b0;
      ratio_code <= 2'd0;
    end else begin
      lrck_q <= lrck;
      if (rise)
        cnt <= '0;
      else if (cnt != {CW{1'b1}})
        cnt <= cnt + 1'b1;
      if (rise)
        armed <= 1'b1;
      if (rise && armed && !locked && hit != 2'd0) begin
        locked     <= 1'b1;
        ratio_code <= hit;
      end
      if (edge_any || div == div_last)
        div <= '0;
      else
        div <= div + 1'b1;
    end
  end

  assign bclk_en  = locked & ~ext_sclk_mode & (div == div_last);
  assign max_bits = ext_sclk_mode      ? MBW'(BITS_WIDE) :
                    !locked            ? '0 :
                    (ratio_code == 2'd2) ? MBW'(BITS_WIDE) : MBW'(BITS_NARROW);

endmodule

// File: rtl/clkratio_sense_chk.sv
module clkratio_sense_chk #(
  parameter int BITS_WIDE = 24
) (
  input logic       mclk,
  input logic       rst_n,
  input logic       lrck,
  input logic       ext_sclk_mode,
  input logic [1:0] ratio_code,
  input logic       locked,
  input logic       bclk_en,
  input logic [$clog2(BITS_WIDE+1)-1:0] max_bits
);

  logic wq;
  always_ff @(posedge mclk) begin
    if (!rst_n) wq <= 1'b0;
    else        wq <= lrck;
  end

  AST_LOCK_STICKY: assert property (@(posedge mclk) disable iff (!rst_n)
    locked |=> locked);                                            // R4
  AST_CODE_FROZEN: assert property (@(posedge mclk) disable iff (!rst_n)
    locked |=> $stable(ratio_code));                               // R4
  AST_LOCK_CODE_VALID: assert property (@(posedge mclk) disable iff (!rst_n)
    locked |-> ratio_code != 2'd0);                                // R2
  AST_UNLOCKED_CODE_ZERO: assert property (@(posedge mclk) disable iff (!rst_n)
    !locked |-> ratio_code == 2'd0);                               // R3
  AST_BCLK_GATED: assert property (@(posedge mclk) disable iff (!rst_n)
    (ext_sclk_mode || !locked) |-> !bclk_en);                      // R7
  AST_EXT_WIDTH: assert property (@(posedge mclk) disable iff (!rst_n)
    ext_sclk_mode |-> max_bits == ($bits(max_bits))'(BITS_WIDE));  // R8
  AST_EDGE_RESTART: assert property (@(posedge mclk) disable iff (!rst_n)
    (lrck != wq) |=> !bclk_en);                                    // R6

endmodule

bind clkratio_sense clkratio_sense_chk #(.BITS_WIDE(BITS_WIDE)) u_chk (
  .mclk(mclk), .rst_n(rst_n), .lrck(lrck), .ext_sclk_mode(ext_sclk_mode),
  .ratio_code(ratio_code), .locked(locked), .bclk_en(bclk_en), .max_bits(max_bits)
);

// File: tb/test_clkratio_sense.sv
`timescale 1ns/1ps
module test_clkratio_sense;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrck = 1'b0;
  logic       ext_sclk_mode = 1'b0;
  logic [1:0] ratio_code;
  logic       locked;
  logic       bclk_en;
  logic [4:0] max_bits;

  int n_vec = 0;
  int n_bad = 0;
  int pulses;
  bit done = 1'b0;

  always #2 mclk = ~mclk;

  clkratio_sense i_clkratio_sense (
    .mclk(mclk), .rst_n(rst_n), .lrck(lrck), .ext_sclk_mode(ext_sclk_mode),
    .ratio_code(ratio_code), .locked(locked), .bclk_en(bclk_en), .max_bits(max_bits)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic ext);
    @(negedge mclk);
    rst_n = 1'b0; lrck = 1'b0; ext_sclk_mode = ext;
    repeat (3) @(negedge mclk);
    rst_n = 1'b1;
  endtask

  task automatic frame(input int hi, input int lo, output int cnt);
    cnt = 0;
    lrck = 1'b1;
    for (int i = 0; i < hi; i++) begin
      @(negedge mclk);
      if (bclk_en) cnt++;
    end
    lrck = 1'b0;
    for (int i = 0; i < lo; i++) begin
      @(negedge mclk);
      if (bclk_en) cnt++;
    end
  endtask

  function automatic int code_of(input int p);
    return (p == 256) ? 1 : (p == 384) ? 2 : (p == 512) ? 3 : 0;
  endfunction

  initial begin : watchdog
    for (int c = 0; c < 200000; c++) begin
      @(posedge mclk);
      if (done) disable watchdog;
    end
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int periods[9] = '{256, 384, 512, 255, 257, 383, 385, 300, 513};
    int code, exp_p, exp_bits;

    do_reset(1'b0);
    chk("R1 locked", locked, 0);
    chk("R1 code", ratio_code, 0);
    chk("R1 bclk_en", bclk_en, 0);

    foreach (periods[k]) begin
      for (int e = 0; e < 2; e++) begin
        int p = periods[k];
        do_reset(e[0]);
        frame(p / 2, p - p / 2, pulses);
        frame(p / 2, p - p / 2, pulses);
        frame(p / 2, p - p / 2, pulses);
        code = code_of(p);
        if (e == 1 || code == 0) exp_p = 0;
        else exp_p = p / ((code == 3) ? 16 : 8);
        if (e == 1) exp_bits = 24;
        else if (code == 0) exp_bits = 0;
        else exp_bits = (code == 2) ? 24 : 16;
        chk((code == 0) ? "R3 locked" : "R2 locked", locked, (code != 0) ? 1 : 0);
        chk((code == 0) ? "R3 code" : "R2 code", ratio_code, code);
        chk("R8 max_bits", max_bits, exp_bits);
        chk((exp_p == 0) ? "R7 pulses" : "R5 pulses", pulses, exp_p);
      end
    end

    // R3: repeated measurement after mismatched periods
    do_reset(1'b0);
    repeat (3) frame(128, 127, pulses);
    chk("R3 unlocked after bad periods", locked, 0);
    chk("R7 no pulses while unlocked", pulses, 0);
    repeat (2) frame(256, 256, pulses);
    chk("R3 later lock", locked, 1);
    chk("R3 later code", ratio_code, 3);

    // R4: frozen code after period change
    do_reset(1'b0);
    repeat (3) frame(192, 192, pulses);
    chk("R4 lock before change", ratio_code, 2);
    repeat (3) frame(150, 150, pulses);
    chk("R4 locked after change", locked, 1);
    chk("R4 code after change", ratio_code, 2);
    chk("R8 max_bits code2", max_bits, 24);

    // R6: divider restart on uneven halves at ratio 384
    do_reset(1'b0);
    repeat (2) frame(192, 192, pulses);
    frame(195, 189, pulses);
    chk("R6 restart pulses", pulses, 195 / 8 + 189 / 8);

    // R7: external mode switched on after lock
    @(negedge mclk);
    ext_sclk_mode = 1'b1;
    frame(192, 192, pulses);
    chk("R7 ext pulses", pulses, 0);
    chk("R8 ext max_bits", max_bits, 24);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule